// File: doc/BRIEF.md
# Block-Ack Transmit Window Tracker

This block follows one transmit queue that carries traffic for one receiver and one traffic class. It keeps a sliding window of up to 64 consecutive frame sequence numbers. For every slot in the window it holds a transmitted flag and an acknowledged flag. When a descriptor is issued, the block gives it the next sequence number and marks that slot as sent.

A received block-ack brings a 12-bit starting sequence number and a 64-bit bitmap. The block lines the bitmap up with its window:

- Each frame that the bitmap confirms produces one completion event.
- Each frame that was sent, is covered by the bitmap and is still unconfirmed produces one retransmit request.
- Frames are rescheduled per frame, so they can complete out of order.

The window start moves forward past leading frames whose completion has already been reported. A 7-bit window-size field limits how many frames may be outstanding. A 7-bit frame-limit field caps how many new frames may go out between two block-acks. Fragmented frames are not handled. The block expects each descriptor to be one whole frame.

Top module: `ba_window_tracker`

## Requirements
- R1: A descriptor is accepted (`issue_ready` high) only while the number of outstanding frames is below the effective window size, so occupancy never exceeds that size or 64.
- R2: The window-size and frame-limit inputs are 7-bit fields. A value of 0 or above 64 acts as 64, which is the default.
- R3: After at most the effective frame limit of new descriptors, no further descriptor is accepted until a block-ack arrives. A block-ack restarts the burst count.
- R4: Accepted descriptors get sequence numbers on `issue_seq` that start at 0 after reset and increase by one modulo 4096.
- R5: Bitmap bit i refers to sequence number (`ba_ssn` + i) modulo 4096. Bits for sequence numbers outside [window start, window start + outstanding) are ignored.
- R6: Each frame newly confirmed by a block-ack gives exactly one completion event on `done_valid`/`done_seq`. Events come one per cycle, nearest the window start first, starting the cycle after the block-ack edge. Completions may therefore be out of sequence order.
- R7: A covered bitmap bit that is clear, for a sent and unconfirmed frame, gives one retransmit request on `retx_valid`/`retx_seq`. Requests come one per cycle, nearest the window start first.
- R8: `win_start` advances by one per cycle past a leading frame that is confirmed and whose completion has been reported. It wraps modulo 4096.
- R9: After reset, `win_start` is 0, `issue_ready` is high, and no completion or retransmit event is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_win_size | input | 7 | Window size, 0 or >64 means 64 |
| cfg_frame_limit | input | 7 | New frames per burst, 0 or >64 means 64 |
| issue_valid | input | 1 | A descriptor is offered |
| issue_ready | output | 1 | The offered descriptor is taken this cycle |
| issue_seq | output | 12 | Sequence number given to the offered descriptor |
| ba_valid | input | 1 | A block-ack is present this cycle |
| ba_ssn | input | 12 | Block-ack starting sequence number |
| ba_bitmap | input | 64 | Block-ack bitmap, bit i for ssn+i |
| retx_valid | output | 1 | Retransmit request |
| retx_seq | output | 12 | Sequence number to retransmit |
| done_valid | output | 1 | Completion event |
| done_seq | output | 12 | Sequence number that completed |
| win_start | output | 12 | Current window start sequence number |

## Verification
The bench targets four corner cases:

- **Modulo alignment.** A block-ack whose start number lies 6 below zero checks the modulo-4096 alignment. A design that subtracted without wrapping would confirm nothing.
- **Bits outside the window.** Bitmaps with set or clear bits beyond the outstanding frames check that those bits are ignored. A design that honoured them would report phantom completions or retransmits.
- **Out-of-order completion.** Two block-acks that confirm odd and then even frames must give completions in the order 1, 3, 0, 2, with the window start held until frame 0 is confirmed.
- **Limits and wrap.** Small window sizes and frame limits must stop acceptance at exactly the configured count. A value of 0 must mean 64. Sixty-five full rounds must wrap the sequence space back to 64.

// File: rtl/ba_win_pkg.sv
package ba_win_pkg;

    localparam int SEQ_W  = 12;
    localparam int SLOTS  = 64;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CFG_W  = 7;

    // Map a raw 7-bit configuration field onto an effective count.
    function automatic logic [CFG_W-1:0] eff_count(input logic [CFG_W-1:0] raw);
        if (raw == '0 || raw > CFG_W'(SLOTS))
            return CFG_W'(SLOTS);
        return raw;
    endfunction

endpackage

// File: rtl/ba_pick_first.sv
// Finds the first set request, searching upward from a base slot with wrap.
module ba_pick_first #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] base,
    output logic          found,
    output logic [IW-1:0] offset,
    output logic [IW-1:0] index
);
    logic [2*N-1:0] dbl;
    logic [N-1:0]   rot;

    always_comb begin
        dbl    = {req, req} >> base;
        rot    = dbl[N-1:0];
        found  = |rot;
        offset = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (rot[k]) offset = IW'(k);
        end
        index = base + offset;
    end
endmodule

// File: rtl/ba_ack_align.sv
// Per-slot alignment of a block-ack bitmap against the live window.
module ba_ack_align #(
    parameter int SEQ_W = 12,
    parameter int N     = 64,
    parameter int IW    = $clog2(N)
) (
    input  logic [SEQ_W-1:0] head,
    input  logic [IW:0]      out_cnt,
    input  logic [SEQ_W-1:0] ssn,
    input  logic [N-1:0]     bitmap,
    output logic [N-1:0]     ack_hit,
    output logic [N-1:0]     nack_hit
);
    for (genvar j = 0; j < N; j++) begin : g_slot
        logic [IW-1:0]    off;
        logic             live;
        logic [SEQ_W-1:0] seq;
        logic [SEQ_W-1:0] bit_pos;
        logic             covered;

        always_comb begin
            off         = IW'(j) - head[IW-1:0];
            live        = {1'b0, off} < out_cnt;
            seq         = head + SEQ_W'(off);
            bit_pos     = seq - ssn;
            covered     = live && (bit_pos < SEQ_W'(N));
            ack_hit[j]  = covered &&  bitmap[bit_pos[IW-1:0]];
            nack_hit[j] = covered && !bitmap[bit_pos[IW-1:0]];
        end
    end
endmodule

// File: rtl/ba_window_tracker.sv
module ba_window_tracker
    import ba_win_pkg::*;
#(
    parameter int SQ_W  = SEQ_W,
    parameter int NSLOT = SLOTS,
    parameter int CW    = CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cfg_win_size,
    input  logic [CW-1:0]    cfg_frame_limit,
    input  logic             issue_valid,
    output logic             issue_ready,
    output logic [SQ_W-1:0]  issue_seq,
    input  logic             ba_valid,
    input  logic [SQ_W-1:0]  ba_ssn,
    input  logic [NSLOT-1:0] ba_bitmap,
    output logic             retx_valid,
    output logic [SQ_W-1:0]  retx_seq,
    output logic             done_valid,
    output logic [SQ_W-1:0]  done_seq,
    output logic [SQ_W-1:0]  win_start
);
    localparam int IW = $clog2(NSLOT);

    typedef struct packed {
        logic [SQ_W-1:0]  head;
        logic [SQ_W-1:0]  next;
        logic [CW-1:0]    burst;
        logic [NSLOT-1:0] sent;
        logic [NSLOT-1:0] acked;
        logic [NSLOT-1:0] retx;
        logic [NSLOT-1:0] done;
    } st_t;

    st_t s_q, s_d;

    logic [CW-1:0]    eff_win, eff_lim;
    logic [SQ_W-1:0]  span;
    logic [IW:0]      out_cnt;
    logic [NSLOT-1:0] ack_hit, nack_hit;
    logic             rx_found, dn_found;
    logic [IW-1:0]    rx_off, rx_idx, dn_off, dn_idx;
    logic [IW-1:0]    head_slot;
    logic             accept, retire;

    assign span      = s_q.next - s_q.head;
    assign out_cnt   = span[IW:0];
    assign head_slot = s_q.head[IW-1:0];

    ba_ack_align #(.SEQ_W(SQ_W), .N(NSLOT), .IW(IW)) i_align (
        .head    (s_q.head),
        .out_cnt (out_cnt),
        .ssn     (ba_ssn),
        .bitmap  (ba_bitmap),
        .ack_hit (ack_hit),
        .nack_hit(nack_hit)
    );

    ba_pick_first #(.N(NSLOT), .IW(IW)) i_pick_retx (
        .req   (s_q.retx),
        .base  (head_slot),
        .found (rx_found),
        .offset(rx_off),
        .index (rx_idx)
    );

    ba_pick_first #(.N(NSLOT), .IW(IW)) i_pick_done (
        .req   (s_q.done),
        .base  (head_slot),
        .found (dn_found),
        .offset(dn_off),
        .index (dn_idx)
    );

    always_comb begin
        eff_win     = eff_count(cfg_win_size);
        eff_lim     = eff_count(cfg_frame_limit);
        issue_ready = (CW'(out_cnt) < eff_win) && (s_q.burst < eff_lim);
        issue_seq   = s_q.next;
        accept      = issue_valid && issue_ready;
        retire      = (out_cnt != '0) && s_q.acked[head_slot] && !s_q.done[head_slot];

        retx_valid  = rx_found;
        retx_seq    = s_q.head + SQ_W'(rx_off);
        done_valid  = dn_found;
        done_seq    = s_q.head + SQ_W'(dn_off);
        win_start   = s_q.head;

        s_d = s_q;

        // Hand out one pending event of each kind.
        if (rx_found) s_d.retx[rx_idx] = 1'b0;
        if (dn_found) s_d.done[dn_idx] = 1'b0;

        // Block-ack merge.
        if (ba_valid) begin
            s_d.burst = '0;
            s_d.done  = s_d.done  | (ack_hit & ~s_q.acked);
            s_d.acked = s_d.acked | ack_hit;
            s_d.retx  = (s_d.retx & ~ack_hit) | (nack_hit & s_q.sent & ~s_q.acked);
        end

        // Retire the leading slot once its completion is out.
        if (retire) begin
            s_d.sent[head_slot]  = 1'b0;
            s_d.acked[head_slot] = 1'b0;
            s_d.retx[head_slot]  = 1'b0;
            s_d.head             = s_q.head + 1'b1;
        end

        // New descriptor.
        if (accept) begin
            s_d.sent[s_q.next[IW-1:0]]  = 1'b1;
            s_d.acked[s_q.next[IW-1:0]] = 1'b0;
            s_d.retx[s_q.next[IW-1:0]]  = 1'b0;
            s_d.done[s_q.next[IW-1:0]]  = 1'b0;
            s_d.next                    = s_q.next + 1'b1;
            s_d.burst                   = s_d.burst + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1: occupancy never exceeds the slot count.
    a_r1_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt <= (IW+1)'(NSLOT));

    // R1/R3: a refused descriptor leaves the sequence counter alone.
    a_r3_refused_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_ready) |=> $stable(issue_seq));

    // R8: the window start only ever steps by one.
    a_r8_head_step: assert property (@(posedge clk) disable iff (!rst_n)
        (win_start != $past(win_start)) |-> (win_start == $past(win_start) + 1'b1));

    // R6: a completion is never reported twice in a row for one frame.
    a_r6_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !(done_valid && done_seq == $past(done_seq)));

    // R7: a retransmit is not repeated unless a new block-ack asked again.
    a_r7_single_retx: assert property (@(posedge clk) disable iff (!rst_n)
        (retx_valid && !ba_valid) |=> !(retx_valid && retx_seq == $past(retx_seq)));

    // R3: a burst never runs past the frame limit plus nothing.
    a_r3_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.burst <= eff_lim) || $past(cfg_frame_limit != cfg_frame_limit));
endmodule

// File: tb/test_ba_window_tracker.sv
module test_ba_window_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cfg_win_size = 7'd64;
    logic [6:0]  cfg_frame_limit = 7'd64;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [11:0] issue_seq;
    logic        ba_valid = 1'b0;
    logic [11:0] ba_ssn = '0;
    logic [63:0] ba_bitmap = '0;
    logic        retx_valid;
    logic [11:0] retx_seq;
    logic        done_valid;
    logic [11:0] done_seq;
    logic [11:0] win_start;

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;
    int retx_cnt = 0;
    int done_log [16];

    always #5ns clk = ~clk;

    ba_window_tracker i_ba_window_tracker (
        .clk(clk), .rst_n(rst_n),
        .cfg_win_size(cfg_win_size), .cfg_frame_limit(cfg_frame_limit),
        .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_seq(issue_seq),
        .ba_valid(ba_valid), .ba_ssn(ba_ssn), .ba_bitmap(ba_bitmap),
        .retx_valid(retx_valid), .retx_seq(retx_seq),
        .done_valid(done_valid), .done_seq(done_seq),
        .win_start(win_start)
    );

    always @(negedge clk) begin
        if (rst_n && done_valid) begin
            if (done_cnt < 16) done_log[done_cnt] = int'(done_seq);
            done_cnt++;
        end
        if (rst_n && retx_valid) retx_cnt++;
    end

    typedef struct packed {
        logic [7:0]  n;
        logic [11:0] ssn;
        logic [63:0] bm;
        logic [7:0]  ed;
        logic [7:0]  er;
        logic [11:0] eh;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'd8,  12'd0,    64'h0000_0000_0000_00FF, 8'd8,  8'd0, 12'd8},
        '{8'd8,  12'd0,    64'h0000_0000_0000_00F5, 8'd6,  8'd2, 12'd1},
        '{8'd4,  12'd2,    64'h0000_0000_0000_0003, 8'd2,  8'd0, 12'd0},
        '{8'd10, 12'd4090, 64'hFFFF_FFFF_FFFF_FFC0, 8'd10, 8'd0, 12'd10},
        '{8'd3,  12'd0,    64'hFFFF_FFFF_FFFF_FFF8, 8'd0,  8'd3, 12'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        issue_valid = 1'b0;
        ba_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        done_cnt = 0;
        retx_cnt = 0;
    endtask

    task automatic issue_n(input int n);
        int acc = 0;
        issue_valid = 1'b1;
        while (acc < n) begin
            if (issue_ready) acc++;
            @(negedge clk);
        end
        issue_valid = 1'b0;
    endtask

    task automatic hold_issue(input int k, output int acc);
        acc = 0;
        issue_valid = 1'b1;
        for (int c = 0; c < k; c++) begin
            if (issue_ready) acc++;
            @(negedge clk);
        end
        issue_valid = 1'b0;
    endtask

    task automatic send_ba(input logic [11:0] ssn, input logic [63:0] bm);
        ba_valid = 1'b1;
        ba_ssn = ssn;
        ba_bitmap = bm;
        @(negedge clk);
        ba_valid = 1'b0;
    endtask

    initial begin
        #1500us;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int acc;
        reset_dut();

        // R9 reset state
        check(win_start == 12'd0, "R9 win_start", int'(win_start), 0);
        check(issue_ready == 1'b1, "R9 issue_ready", int'(issue_ready), 1);
        check(!done_valid && !retx_valid, "R9 no events", int'(done_valid | retx_valid), 0);
        check(issue_seq == 12'd0, "R4 first seq", int'(issue_seq), 0);

        // Vector table: R5 R6 R7 R8
        foreach (VECS[v]) begin
            reset_dut();
            issue_n(int'(VECS[v].n));
            send_ba(VECS[v].ssn, VECS[v].bm);
            repeat (100) @(negedge clk);
            check(done_cnt == int'(VECS[v].ed), "R6/R5 completions", done_cnt, int'(VECS[v].ed));
            check(retx_cnt == int'(VECS[v].er), "R7/R5 retransmits", retx_cnt, int'(VECS[v].er));
            check(win_start == VECS[v].eh, "R8 win_start", int'(win_start), int'(VECS[v].eh));
        end

        // R6 out-of-order completion and timing
        reset_dut();
        issue_n(4);
        send_ba(12'd0, 64'hA);
        check(done_valid && done_seq == 12'd1, "R6 first event next cycle", int'(done_seq), 1);
        check(retx_valid && retx_seq == 12'd0, "R7 lowest retx first", int'(retx_seq), 0);
        repeat (10) @(negedge clk);
        check(win_start == 12'd0, "R8 head held", int'(win_start), 0);
        send_ba(12'd0, 64'h5);
        repeat (20) @(negedge clk);
        check(done_cnt == 4 && done_log[0] == 1 && done_log[1] == 3 &&
              done_log[2] == 0 && done_log[3] == 2, "R6 order 1,3,0,2",
              done_log[2], 0);
        check(retx_cnt == 2, "R7 no retx for acked", retx_cnt, 2);
        check(win_start == 12'd4, "R8 head after all acked", int'(win_start), 4);

        // R1 window size
        reset_dut();
        cfg_win_size = 7'd5;
        hold_issue(20, acc);
        check(acc == 5, "R1 window cap", acc, 5);
        check(issue_ready == 1'b0, "R1 ready low when full", int'(issue_ready), 0);

        // R3 frame limit
        reset_dut();
        cfg_win_size = 7'd64;
        cfg_frame_limit = 7'd3;
        hold_issue(10, acc);
        check(acc == 3, "R3 burst cap", acc, 3);
        send_ba(12'd0, 64'h7);
        hold_issue(10, acc);
        check(acc == 3, "R3 burst reopened", acc, 3);

        // R2 zero means 64
        reset_dut();
        cfg_win_size = 7'd0;
        cfg_frame_limit = 7'd0;
        hold_issue(80, acc);
        check(acc == 64, "R2 zero config", acc, 64);
        reset_dut();
        cfg_win_size = 7'd100;
        cfg_frame_limit = 7'd64;
        hold_issue(80, acc);
        check(acc == 64, "R2 oversize config", acc, 64);

        // R4 / R8 wrap over 4096
        reset_dut();
        cfg_win_size = 7'd64;
        for (int r = 0; r < 65; r++) begin
            logic [11:0] h;
            h = win_start;
            issue_n(64);
            send_ba(h, 64'hFFFF_FFFF_FFFF_FFFF);
            repeat (140) @(negedge clk);
        end
        check(done_cnt == 4160, "R6 total completions", done_cnt, 4160);
        check(win_start == 12'd64, "R8 wrap", int'(win_start), 64);
        check(issue_seq == 12'd64, "R4 wrap", int'(issue_seq), 64);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule